// File: doc/BRIEF.md
# Receive Descriptor Ring Write-Back Engine

This engine keeps a circular ring of receive descriptors in a local descriptor RAM and places an incoming byte stream into the buffers those descriptors point to. Host software reserves a group of descriptors for one expected frame. The first descriptor of the group carries a start mark, and the others follow it in ring order. The engine takes one descriptor after another while the frame runs. It emits one store strobe per byte, giving the descriptor index and the byte offset. The data buffer memory itself lies outside the block.

When the frame ends, the engine returns every used descriptor to the host. It writes the final status and byte count into the descriptor where the frame stopped. It then releases any descriptors of the group that were reserved but never reached, and moves its position to the next descriptor that carries a start mark. A single-cycle interrupt pulse follows the last write. While the descriptor at the current position is still held by the host, the engine discards whole frames and checks that descriptor again at a fixed poll interval.

Top module: `rx_ring_wb`

## Requirements
- R1: A descriptor word of DW = 4+2*CW bits holds, from the top bit down: the ownership bit (bit DW-1, 1 = engine owns it), the chain-start bit (DW-2), the end bit (DW-3), the error bit (DW-4), the buffer size (bits 2*CW-1..CW) and the message byte count (bits CW-1..0).
- R2: Each accepted byte of a frame is stored in order, at offsets 0 up to size-1 of the current descriptor. The first byte goes to offset 0 of the descriptor at the current position, and bw_desc/bw_off report each store.
- R3: When the current buffer is full, the engine moves on to the next ring entry only if that entry has ownership=1, chain-start=0 and a non-zero size. Otherwise it marks a buffer error on the current descriptor and drops the rest of the frame without storing it.
- R4: The descriptor where the frame stopped is written with ownership=0, end=1, and error=1 if the last byte carried s_err or a buffer error occurred. Its count is set to the number of bytes stored for the frame, and its start bit and size are kept.
- R5: Each earlier descriptor filled by the frame is written with ownership=0, end=0 and error=0. Its start bit, size and count are kept.
- R6: After the stop descriptor, every following descriptor that is still engine-owned is released with ownership=0 and end=0, all its other fields kept. This continues up to the first entry with chain-start=1, or up to the frame's head entry.
- R7: A descriptor with ownership=0 is never written. This covers entries that lie inside a reserved group.
- R8: After a frame, the current position becomes the entry where the release walk of R6 stopped.
- R9: The ring holds 2^ring_log2 entries (ring_log2 from 0 to AW). Every descriptor index wraps from the last entry back to 0.
- R10: irq is high for exactly one cycle after the last write-back of each stored frame. s_ready stays low while write-back is in progress.
- R11: While the descriptor at the current position has ownership=0, incoming frames are consumed and discarded with no store, no write and no irq. The descriptor is re-read every POLL_CYC cycles, and only at a frame boundary, so that a later frame is stored once ownership is granted.
- R12: During reset irq is low, no descriptor write occurs, and the current position is entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_log2 | input | 3 | Log2 of the ring length |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Byte is the last of its frame |
| s_err | input | 1 | Frame error, sampled with the last byte |
| s_ready | output | 1 | Engine accepts a byte this cycle |
| bw_valid | output | 1 | Byte store strobe |
| bw_desc | output | 7 | Descriptor index of the store |
| bw_off | output | 12 | Byte offset in that buffer |
| bw_data | output | 8 | Byte to store |
| d_addr | output | 7 | Descriptor RAM address (read is combinational) |
| d_rdata | input | 28 | Descriptor word at d_addr |
| d_we | output | 1 | Descriptor write enable |
| d_wdata | output | 28 | Descriptor word to write |
| irq | output | 1 | Frame-done pulse |

## Verification
The assertions assume that the host changes a descriptor only while the host owns it. They also assume that the host never touches the descriptor at the current position once the engine has taken it. This is what makes "every written descriptor was engine-owned" a valid property. The bench rewrites the ring only between frames, after the interrupt has settled. It leaves the current head untouched whenever the engine holds it, and it grants ownership of a waiting head only with no frame in flight. Random ownership, start marks, sizes (including zero), frame lengths and byte gaps then drive short frames, long frames, chain wraps and buffer errors within those rules.

// File: rtl/rx_ring_wb.sv
module rx_ring_wb #(
  parameter int CW = 12,
  parameter int AW = 7,
  parameter int POLL_CYC = 16,
  localparam int LW = $clog2(AW + 1),
  localparam int DW = 4 + 2 * CW,
  localparam int PW = $clog2(POLL_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] ring_log2,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  input  logic          s_err,
  output logic          s_ready,
  output logic          bw_valid,
  output logic [AW-1:0] bw_desc,
  output logic [CW-1:0] bw_off,
  output logic [7:0]    bw_data,
  output logic [AW-1:0] d_addr,
  input  logic [DW-1:0] d_rdata,
  output logic          d_we,
  output logic [DW-1:0] d_wdata,
  output logic          irq
);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_RX, S_DROP, S_FILL, S_REL} st_t;

  st_t           st;
  logic [AW-1:0] hd, ix, endi, w;
  logic [CW-1:0] off, bsz, cnt;
  logic          perr, wdrop, irq_q;
  logic [PW-1:0] pc;

  wire [AW-1:0] mask  = AW'((32'd1 << ring_log2) - 32'd1);
  wire [AW-1:0] ix_nx = (ix + 1'b1) & mask;
  wire [AW-1:0] w_nx  = (w + 1'b1) & mask;

  wire          r_own  = d_rdata[DW-1];
  wire          r_stp  = d_rdata[DW-2];
  wire          r_err  = d_rdata[DW-4];
  wire [CW-1:0] r_size = d_rdata[2*CW-1:CW];
  wire [CW-1:0] r_cnt  = d_rdata[CW-1:0];
  logic         unused_enp;
  assign unused_enp = d_rdata[DW-3];

  wire full      = (off == bsz);
  wire take      = full && r_own && !r_stp && (r_size != '0);
  wire at_end    = (w == endi);
  wire stop      = (w == hd) || r_stp;
  wire wait_busy = s_valid ? !s_last : wdrop;

  assign s_ready  = (st == S_RX) || (st == S_DROP) || (st == S_WAIT);
  assign bw_valid = (st == S_RX) && s_valid && (!full || take);
  assign bw_desc  = full ? ix_nx : ix;
  assign bw_off   = full ? '0 : off;
  assign bw_data  = s_data;
  assign irq      = irq_q;

  always_comb begin
    case (st)
      S_RX:          d_addr = full ? ix_nx : ix;
      S_FILL, S_REL: d_addr = w;
      default:       d_addr = hd;
    endcase
  end

  assign d_we    = (st == S_FILL) || ((st == S_REL) && !stop && r_own);
  assign d_wdata = (st == S_REL) ? {1'b0, r_stp, 1'b0, r_err, r_size, r_cnt} :
                   at_end        ? {1'b0, r_stp, 1'b1, perr, r_size, cnt} :
                                   {1'b0, r_stp, 2'b00, r_size, r_cnt};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      hd <= '0; ix <= '0; endi <= '0; w <= '0;
      off <= '0; bsz <= '0; cnt <= '0;
      perr <= 1'b0; wdrop <= 1'b0; irq_q <= 1'b0;
      pc <= '0;
    end else begin
      irq_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (r_own) begin
            st <= S_RX; ix <= hd; bsz <= r_size;
            off <= '0; cnt <= '0; perr <= 1'b0;
          end else begin
            st <= S_WAIT; pc <= PW'(POLL_CYC - 1); wdrop <= 1'b0;
          end
        end
        S_WAIT: begin
          if (s_valid) wdrop <= !s_last;
          if (pc == '0) begin
            if (!wait_busy) st <= S_IDLE;
          end else begin
            pc <= pc - 1'b1;
          end
        end
        S_RX: begin
          if (s_valid) begin
            if (!full || take) begin
              cnt <= cnt + 1'b1;
              if (full) begin
                ix <= ix_nx; bsz <= r_size; off <= CW'(1);
              end else begin
                off <= off + 1'b1;
              end
              if (s_last) begin
                endi <= full ? ix_nx : ix;
                perr <= s_err; w <= hd; st <= S_FILL;
              end
            end else begin
              endi <= ix; perr <= 1'b1; w <= hd;
              st <= s_last ? S_FILL : S_DROP;
            end
          end
        end
        S_DROP: if (s_valid && s_last) st <= S_FILL;
        S_FILL: begin
          w <= w_nx;
          if (at_end) st <= S_REL;
        end
        S_REL: begin
          if (stop) begin
            hd <= w; irq_q <= 1'b1; st <= S_IDLE;
          end else begin
            w <= w_nx;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rx_ring_wb_chk.sv
module rx_ring_wb_chk #(
  parameter int CW = 12,
  parameter int AW = 7,
  localparam int LW = $clog2(AW + 1),
  localparam int DW = 4 + 2 * CW
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] ring_log2,
  input logic          s_valid,
  input logic          s_ready,
  input logic          bw_valid,
  input logic [AW-1:0] bw_desc,
  input logic [AW-1:0] d_addr,
  input logic [DW-1:0] d_rdata,
  input logic          d_we,
  input logic [DW-1:0] d_wdata,
  input logic          irq
);

  p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_no_accept_in_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    d_we |-> !s_ready);

  p_write_only_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    d_we |-> d_rdata[DW-1]);

  p_write_returns_own_r4: assert property (@(posedge clk) disable iff (!rst_n)
    d_we |-> !d_wdata[DW-1]);

  p_store_needs_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bw_valid |-> (s_valid && s_ready));

  p_addr_in_ring_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (AW'(d_addr >> ring_log2) == '0) && (!bw_valid || (AW'(bw_desc >> ring_log2) == '0)));

  p_reset_quiet_r12: assert property (@(posedge clk)
    !rst_n |-> (!d_we && !irq));

endmodule

bind rx_ring_wb rx_ring_wb_chk #(.CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ring_log2(ring_log2), .s_valid(s_valid),
  .s_ready(s_ready), .bw_valid(bw_valid), .bw_desc(bw_desc), .d_addr(d_addr),
  .d_rdata(d_rdata), .d_we(d_we), .d_wdata(d_wdata), .irq(irq)
);

// File: tb/rx_ring_wb_test.sv
`timescale 1ns/1ps
module rx_ring_wb_test;
  localparam int POLL = 16;

  logic        clk = 0, rst_n = 0;
  logic [2:0]  ring_log2 = 0;
  logic        s_valid = 0, s_last = 0, s_err = 0;
  logic [7:0]  s_data = 0;
  logic        s_ready, bw_valid, d_we, irq;
  logic [6:0]  bw_desc, d_addr;
  logic [11:0] bw_off;
  logic [7:0]  bw_data;
  logic [27:0] d_rdata, d_wdata;

  logic [27:0] ram [128];
  logic [27:0] stage [128];
  logic [27:0] mr [128];
  int          cat [128];
  logic        load = 0;

  int checks = 0, errors = 0;
  int lg = 0, mh = 0;
  int ed [64], eo [64], en;
  int gd [1024], go [1024], gtot = 0, irq_cnt = 0;

  always #5 clk = ~clk;

  rx_ring_wb #(.POLL_CYC(POLL)) uut (
    .clk(clk), .rst_n(rst_n), .ring_log2(ring_log2), .s_valid(s_valid),
    .s_data(s_data), .s_last(s_last), .s_err(s_err), .s_ready(s_ready),
    .bw_valid(bw_valid), .bw_desc(bw_desc), .bw_off(bw_off), .bw_data(bw_data),
    .d_addr(d_addr), .d_rdata(d_rdata), .d_we(d_we), .d_wdata(d_wdata), .irq(irq)
  );

  assign d_rdata = ram[d_addr];

  always @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < 128; i++) ram[i] <= stage[i];
    end else if (d_we) begin
      ram[d_addr] <= d_wdata;
    end
  end

  always @(negedge clk) begin
    #2;
    if (bw_valid) begin
      gd[gtot % 1024] = bw_desc;
      go[gtot % 1024] = bw_off;
      gtot++;
    end
    if (irq) irq_cnt++;
  end

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end

  // R1 field positions: own 27, start 26, end 25, error 24, size 23:12, count 11:0
  function automatic int sz(input logic [27:0] d);
    return int'(d[23:12]);
  endfunction

  function automatic logic [27:0] rnd_desc();
    logic [27:0] d;
    d[27] = ($urandom % 4) != 0;
    d[26] = ($urandom % 3) == 0;
    d[25] = $urandom % 2;
    d[24] = $urandom % 2;
    d[23:12] = 12'($urandom % 7);
    d[11:0] = 12'($urandom);
    return d;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load_stage();
    @(negedge clk); load = 1;
    @(negedge clk); load = 0;
  endtask

  task automatic model_frame(input int n, input bit e);
    int ix, off, stored, w, mask, nx;
    bit berr;
    mask = (1 << lg) - 1;
    en = 0; ix = mh; off = 0; stored = 0; berr = 0;
    for (int k = 0; k < n; k++) begin
      if (off < sz(mr[ix])) begin
        ed[en] = ix; eo[en] = off; en++; off++; stored++;
      end else begin
        nx = (ix + 1) & mask;
        if (mr[nx][27] && !mr[nx][26] && sz(mr[nx]) != 0) begin
          ix = nx; ed[en] = ix; eo[en] = 0; en++; off = 1; stored++;
        end else begin
          berr = 1;
          break;
        end
      end
    end
    for (int i = 0; i < 128; i++) cat[i] = 0;
    w = mh;
    forever begin
      if (w == ix) begin
        mr[w] = {1'b0, mr[w][26], 1'b1, e | berr, mr[w][23:12], 12'(stored)};
        cat[w] = 1;
        break;
      end
      mr[w] = {1'b0, mr[w][26], 2'b00, mr[w][23:0]};
      cat[w] = 2;
      w = (w + 1) & mask;
    end
    w = (ix + 1) & mask;
    while (w != mh && !mr[w][26]) begin
      if (mr[w][27]) begin
        mr[w][27] = 0; mr[w][25] = 0; cat[w] = 3;
      end
      w = (w + 1) & mask;
    end
    mh = w;
  endtask

  task automatic send_frame(input int n, input bit e);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if ($urandom % 4 == 0) begin
        s_valid = 0;
        @(negedge clk);
      end
      s_valid = 1; s_data = 8'($urandom);
      s_last = (k == n - 1); s_err = e && (k == n - 1);
      forever begin
        #1;
        if (s_ready) break;
        @(negedge clk);
      end
    end
    @(negedge clk);
    s_valid = 0; s_last = 0; s_err = 0;
  endtask

  task automatic compare_ring();
    int L, bad;
    string tag;
    L = 1 << lg; bad = -1;
    for (int i = 0; i < L; i++) if (bad < 0 && ram[i] !== mr[i]) bad = i;
    if (bad < 0) begin
      chk(1, "R1 R4 R5 R6 R7 ring", 0, 0);
    end else begin
      case (cat[bad])
        1: tag = "R1 R4 stop descriptor";
        2: tag = "R5 filled descriptor";
        3: tag = "R6 released descriptor";
        default: tag = "R7 untouched descriptor";
      endcase
      chk(0, tag, int'(ram[bad]), int'(mr[bad]));
    end
  endtask

  task automatic step(input bit keep);
    int st0, ic, n, L, bad;
    bit e;
    L = 1 << lg;
    if (!keep) begin
      for (int i = 0; i < L; i++) begin
        if (!(i == mh && mr[i][27])) begin
          stage[i] = rnd_desc();
          if (i == mh) stage[i][27:26] = 2'b01;
        end
      end
      load_stage();
      for (int i = 0; i < L; i++) mr[i] = stage[i];
    end
    if (!mr[mh][27]) begin
      if ($urandom % 2) begin
        st0 = gtot; ic = irq_cnt;
        send_frame(1 + $urandom % 10, 0);
        repeat (10) @(negedge clk);
        chk(irq_cnt == ic, "R11 no irq on discarded frame", irq_cnt - ic, 0);
        chk(gtot == st0, "R11 no store on discarded frame", gtot - st0, 0);
        compare_ring();
      end
      stage[mh][27] = 1; load_stage(); mr[mh][27] = 1;
      repeat (POLL + 6) @(negedge clk);
    end
    n = 1 + $urandom % 14;
    e = ($urandom % 4) == 0;
    st0 = gtot; ic = irq_cnt;
    model_frame(n, e);
    send_frame(n, e);
    for (int t = 0; t < 400 && irq_cnt == ic; t++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(irq_cnt == ic + 1, "R10 one irq per stored frame", irq_cnt - ic, 1);
    bad = (gtot - st0 == en) ? -1 : 99;
    for (int k = 0; k < en && bad < 0; k++)
      if (gd[(st0 + k) % 1024] != ed[k] || go[(st0 + k) % 1024] != eo[k]) bad = k;
    if (bad == 99)
      chk(0, "R2 R3 store count", gtot - st0, en);
    else if (bad >= 0)
      chk(0, "R2 R3 R8 R9 store place", gd[(st0 + bad) % 1024] * 4096 + go[(st0 + bad) % 1024],
          ed[bad] * 4096 + eo[bad]);
    else
      chk(1, "R2 R3 R8 R9 stores", 0, 0);
    compare_ring();
  endtask

  task automatic do_reset(input int l);
    @(negedge clk);
    rst_n = 0; lg = l; ring_log2 = 3'(l); mh = 0;
    for (int i = 0; i < 128; i++) begin stage[i] = '0; mr[i] = '0; end
    load = 1;
    repeat (3) @(negedge clk);
    load = 0;
    chk(irq == 0, "R12 irq low in reset", irq, 0);
    chk(d_we == 0, "R12 no write in reset", d_we, 0);
    chk(d_addr == 0, "R12 position 0 in reset", d_addr, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int lgs [5];
    lgs = '{0, 2, 3, 7, 1};
    // directed: short frame in a long reserved group (R6, R7, R8)
    do_reset(3);
    stage[0] = {4'b1100, 12'd4, 12'd0};
    stage[1] = {4'b1000, 12'd4, 12'd0};
    stage[2] = {4'b0011, 12'd4, 12'd7};
    stage[3] = {4'b1000, 12'd4, 12'd0};
    stage[4] = {4'b1100, 12'd3, 12'd0};
    for (int i = 5; i < 8; i++) stage[i] = {4'b0100, 12'd2, 12'd0};
    load_stage();
    for (int i = 0; i < 8; i++) mr[i] = stage[i];
    repeat (POLL + 6) @(negedge clk);
    step(1);
    chk(mh == 4, "R8 head skips to next start", mh, 4);
    for (int r = 0; r < 5; r++) begin
      do_reset(lgs[r]);
      for (int f = 0; f < 30; f++) step(0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule